// File: doc/BRIEF.md
# Delta-Sigma Dithered Pulse-Width Modulator

This block turns a wide density word into a pulse stream whose period is fixed and whose average duty has fine resolution. The word has two fields. The upper field sets a coarse pulse width on a down-counting PWM whose period is 2^PWM_W clocks. The lower field is added into a first-order delta-sigma accumulator once per PWM period. In any period where that addition carries out, the pulse is one count wider. Over many periods the pulse width averages to the coarse value plus the lower field divided by 2^DSM_W. The output frequency stays the same for every density.

A one-clock strobe marks the last clock of every period. At that strobe the block captures the density word and the new carry. They take effect together at the start of the next period. A change to the density input therefore reaches the output only at a period boundary, and a pulse never changes width partway through.

Top module: `ds_dither_pwm`

## Requirements
- R1: While reset is high and in the first clock after it falls, `pwm_o` and `tc_o` are low. The first period after reset is a full 2^PWM_W clocks with `pwm_o` low throughout. The accumulator starts from zero.
- R2: Every period lasts exactly 2^PWM_W clocks for any density. The internal counter counts down from 2^PWM_W-1 to 0.
- R3: `tc_o` is high for exactly one clock per period, the clock in which the counter is 0.
- R4: In each period, `pwm_o` is high while the counter is below the coarse width and low otherwise. The pulse is therefore one contiguous run at the end of the period, and its length is the coarse width when the dither bit is 0.
- R5: When the dither bit is 1, the comparison also includes equality, so the pulse is exactly one count longer. A coarse width of 2^PWM_W-1 with the dither bit set gives a period that is high throughout.
- R6: The accumulator adds the lower field only at `tc_o`. The carry out of that DSM_W-bit addition becomes the dither bit for the next period.
- R7: `density_i` is sampled only in the `tc_o` clock. Changes at any other time have no effect on the output of the current period.
- R8: Bits [DEN_W-1:DSM_W] of `density_i` are the coarse width. Bits [DSM_W-1:0] are the accumulator increment.
- R9: With the default widths, starting from reset and holding a density of 20000, eight consecutive periods give seven pulses of 78 clocks and one of 79.
- R10: A density of 0 keeps `pwm_o` low. A lower field of 2^(DSM_W-1) alternates the pulse width between the coarse value and one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| density_i | input | PWM_W+DSM_W | Density word: coarse width in the upper field, accumulator increment in the lower field |
| pwm_o | output | 1 | Modulated output |
| tc_o | output | 1 | One-clock strobe in the last clock of each period |

## Verification
A corrupt accumulator shows up as a pulse-width sequence that departs from the bench's running model. It is visible by the end of the first period that uses the bad carry, which is at most one period after the fault. A wrong counter or a wrong terminal count shows up within one period as a period length other than 2^PWM_W or as a second strobe. A capture register that updates outside the strobe shows up as a pulse width that follows a density change made mid-period.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
    localparam int COARSE_W_DEF = 8;
    localparam int FRAC_W_DEF   = 8;

    // Comparison mode of the width comparator
    typedef enum logic {
        CMP_BELOW   = 1'b0,   // counter <  width
        CMP_BELOWEQ = 1'b1    // counter <= width
    } cmp_mode_e;
endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o,
    output logic         tc_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_q - 1'b1;   // wraps 0 -> all ones
    end

    assign cnt_o = cnt_q;
    assign tc_o  = (cnt_q == '0);
endmodule

// File: rtl/dspwm_accum.sv
module dspwm_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic [W-1:0] inc_i,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
    assign carry_o = sum[W];

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (step_i) acc_q <= sum[W-1:0];
    end
endmodule

// File: rtl/dspwm_compare.sv
module dspwm_compare
    import dspwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] width_i,
    input  cmp_mode_e    mode_i,
    output logic         level_o
);
    always_comb begin
        unique case (mode_i)
            CMP_BELOWEQ: level_o = (cnt_i <= width_i);
            default:     level_o = (cnt_i <  width_i);
        endcase
    end
endmodule

// File: rtl/ds_dither_pwm.sv
module ds_dither_pwm
    import dspwm_pkg::*;
#(
    parameter int PWM_W = COARSE_W_DEF,
    parameter int DSM_W = FRAC_W_DEF,
    localparam int DEN_W = PWM_W + DSM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEN_W-1:0] density_i,
    output logic             pwm_o,
    output logic             tc_o
);
    logic [PWM_W-1:0] cnt;
    logic             tc;
    logic             carry;
    logic [PWM_W-1:0] coarse_q;
    cmp_mode_e        mode_q;

    dspwm_counter #(.W(PWM_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt),
        .tc_o  (tc)
    );

    dspwm_accum #(.W(DSM_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (tc),
        .inc_i   (density_i[DSM_W-1:0]),
        .carry_o (carry)
    );

    // Width and comparison mode are captured together at the period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
            mode_q   <= CMP_BELOW;
        end else if (tc) begin
            coarse_q <= density_i[DEN_W-1:DSM_W];
            mode_q   <= carry ? CMP_BELOWEQ : CMP_BELOW;
        end
    end

    dspwm_compare #(.W(PWM_W)) u_cmp (
        .cnt_i   (cnt),
        .width_i (coarse_q),
        .mode_i  (mode_q),
        .level_o (pwm_o)
    );

    assign tc_o = tc;
endmodule

// File: rtl/dspwm_checker.sv
module dspwm_checker #(
    parameter int PWM_W = 8,
    localparam int PER = 1 << PWM_W
) (
    input logic             clk,
    input logic             rst,
    input logic [PWM_W-1:0] cnt,
    input logic             tc,
    input logic             pwm,
    input logic [PWM_W-1:0] coarse,
    input logic             mode
);
    logic [PWM_W:0] per_cnt;
    logic [PWM_W:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || tc) begin
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            per_cnt <= per_cnt + 1'b1;
            hi_cnt  <= hi_cnt + {{PWM_W{1'b0}}, pwm};
        end
    end

    assert_period_len_R2: assert property (@(posedge clk) disable iff (rst)
        tc == (per_cnt == (PWM_W+1)'(PER - 1)));

    assert_tc_single_R3: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

    assert_low_above_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt > coarse) |-> !pwm);

    assert_width_R5: assert property (@(posedge clk) disable iff (rst)
        tc |-> ((hi_cnt + {{PWM_W{1'b0}}, pwm}) == ({1'b0, coarse} + {{PWM_W{1'b0}}, mode})));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tc |=> ($stable(coarse) && $stable(mode)));
endmodule

bind ds_dither_pwm dspwm_checker #(.PWM_W(PWM_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt),
    .tc     (tc_o),
    .pwm    (pwm_o),
    .coarse (coarse_q),
    .mode   (mode_q)
);

// File: tb/sim_ds_dither_pwm.sv
module sim_ds_dither_pwm;
    localparam int PW  = 8;
    localparam int DW  = 8;
    localparam int PER = 1 << PW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PW+DW-1:0]  den = '0;
    logic              pwm;
    logic              tc;

    int          nchk = 0;
    int          nfail = 0;
    logic [DW-1:0] acc_m = '0;

    always #2 clk = ~clk;

    ds_dither_pwm #(.PWM_W(PW), .DSM_W(DW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .density_i (den),
        .pwm_o     (pwm),
        .tc_o      (tc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected width from the requirements: coarse field plus carry of the model accumulator
    function automatic int next_width(input logic [PW+DW-1:0] d, output logic [DW-1:0] acc_n,
                                      input logic [DW-1:0] acc);
        logic [DW:0] s;
        s = {1'b0, acc} + {1'b0, d[DW-1:0]};
        acc_n = s[DW-1:0];
        return int'(d[PW+DW-1:DW]) + int'(s[DW]);
    endfunction

    // Called at the negedge of a tc clock; measures the following period
    task automatic run_period(input logic [PW+DW-1:0] d, input bit scramble, output int w);
        int hi = 0, tcs = 0, tcpos = -1, rises = 0, e;
        logic prev = 1'b0, last = 1'b0;
        logic [DW-1:0] acc_n;
        den = d;
        e = next_width(d, acc_n, acc_m);
        acc_m = acc_n;
        for (int i = 0; i < PER; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pwm) hi++;
            if (pwm && !prev) rises++;
            prev = pwm;
            last = pwm;
            if (tc) begin tcs++; tcpos = i; end
            if (scramble && i == PER / 2) den = (PW+DW)'($urandom);   // R7 mid-period change
        end
        chk(hi == e, "R4 R5 R6 R7 R8 width", hi, e);
        chk(tcs == 1 && tcpos == PER - 1, "R2 R3 period/strobe", tcpos, PER - 1);
        chk(rises <= 1 && (e == 0 || last), "R4 end-aligned pulse", rises, (e > 0) ? 1 : 0);
        w = hi;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int w, n78, n79, hi0, tcs0;
        int wa [4];
        void'($urandom(32'd20240613));
        den = 16'd20000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pwm == 1'b0 && tc == 1'b0, "R1 reset outputs", {pwm, tc}, 0);
        @(negedge clk);
        rst = 1'b0;
        chk(pwm == 1'b0 && tc == 1'b0, "R1 after release", {pwm, tc}, 0);
        hi0 = 0; tcs0 = 0;
        for (int i = 1; i < PER; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pwm) hi0++;
            if (tc) tcs0++;
        end
        chk(hi0 == 0 && tcs0 == 1 && tc, "R1 first idle period", hi0, 0);

        // R9: 20000 -> coarse 78, increment 32
        n78 = 0; n79 = 0;
        for (int k = 0; k < 8; k++) begin
            run_period(16'd20000, 1'b0, w);
            if (w == 78) n78++;
            if (w == 79) n79++;
        end
        chk(n78 == 7 && n79 == 1, "R9 seven 78 one 79", n79, 1);

        // R10: zero density stays low
        for (int k = 0; k < 2; k++) begin
            run_period(16'd0, 1'b0, w);
            chk(w == 0, "R10 zero density", w, 0);
        end

        // R10: half increment alternates
        for (int k = 0; k < 4; k++) run_period({8'd10, 8'd128}, 1'b0, wa[k]);
        chk(wa[0] != wa[1] && wa[1] != wa[2] && wa[2] != wa[3], "R10 alternation", wa[1], wa[0]);

        // R5: full-scale corners
        for (int k = 0; k < 4; k++) run_period(16'hFFFF, 1'b0, w);
        run_period(16'hFF00, 1'b0, w);
        chk(w == PER - 1, "R5 coarse max no dither", w, PER - 1);
        run_period({8'd0, 8'd63}, 1'b0, w);
        run_period(16'h00FF, 1'b0, w);

        // Random densities with mid-period disturbance (R7)
        for (int k = 0; k < 40; k++) run_period((PW+DW)'($urandom), 1'b1, w);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule